// File: doc/BRIEF.md
# Slave-Port Arbiter with Idle Parking

This block sits at one slave port of a multi-master bus matrix. Up to five masters raise request lines toward the slave, and the arbiter drives a one-hot grant that picks which master the slave is connected to. It also reports whether any master is connected and the index of that master. A burst, or tenure, runs while the connected master keeps its request high. It ends on the master's last-beat strobe or when a programmable slot-cycle budget runs out. Masters that request at the same arbitration point are served in round-robin order.

When nobody is requesting, the slave is parked in one of three configurable ways. It can be disconnected, left on the master that used it last, or placed on a fixed master. Parking decides whether the next burst loses a cycle to make the connection. A master that is already connected starts its burst in the same cycle that it raises its request. A master that is not connected receives its grant one cycle later.

The configuration is written through a write strobe and three field inputs. The written value waits in a shadow copy and becomes active only at the next arbitration point, so a running tenure always finishes under the settings it started with.

Top module: `slave_arb_park`

## Requirements
- R1: `gnt` is one-hot or zero, with bit i meaning master i. `connected` is high exactly when a grant bit is set, and `conn_idx` then holds that bit's index.
- R2: An arbitration point is any cycle that does not continue a tenure. At such a point, the winner is the first requesting master found by searching upward, wrapping from 4 to 0, starting with the index after `conn_idx`. Its grant appears in the next cycle.
- R3: A beat is a cycle with `req[conn_idx]` high while `connected` is high. A beat with `last_beat` high ends the tenure. That master's request is ignored in the arbitration of that cycle. The grant does not change while a tenure continues.
- R4: With a slot limit S between 1 and 255, a tenure ends after its S-th beat. If no other master requests at that point, the owner keeps the slave with no gap. S = 0 means no limit.
- R5: Park mode 0 (none) and the reserved mode 3: at an arbitration point with no eligible request, the slave is disconnected. A request then gets its grant one cycle later.
- R6: Park mode 1 (last): at an arbitration point with no eligible request, the slave stays on, or reconnects to, the master at `conn_idx`. That master's next request is served in the same cycle it appears.
- R7: Park mode 2 (fixed): at an arbitration point with no eligible request, the slave connects to the master given by the 3-bit fixed-index field. A field value above 4 parks on master 0.
- R8: A connected master that raises its request at an arbitration point keeps the slave, even when other masters request in the same cycle.
- R9: A configuration write (`cfg_we` with the `cfg_slot`, `cfg_mode` and `cfg_fix` fields) is first used at the arbitration point after the write cycle. A write during a tenure does not change that tenure's slot limit.
- R10: After reset the mode is last-master (1), the slave is connected to master 0, and the slot limit is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 5 | Request lines, bit i from master i |
| last_beat | input | 1 | Final-beat strobe from the connected master |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 8 | Slot-cycle limit, 0 for no limit |
| cfg_mode | input | 2 | Park mode: 0 none, 1 last, 2 fixed, 3 reserved (acts as none) |
| cfg_fix | input | 3 | Fixed park master index |
| gnt | output | 5 | One-hot grant to the slave port |
| connected | output | 1 | A master is connected |
| conn_idx | output | 3 | Index of the connected (or last connected) master |

## Verification
The in-RTL properties watch, on every cycle, that the grant stays one-hot and does not move during a tenure. They also check that the round-robin winner becomes the owner one cycle later, that each park mode lands on the right master, that a last beat hands the slave to another requester, that the beat counter stays below the slot limit, and that the active configuration changes only at arbitration points. Some behaviours show only as cycle counts in a scenario, so only the bench can show them: the one-cycle connection penalty in no-park mode, the zero-latency start of a parked master, an unbroken tenure when the slot limit expires with no rival, a mid-burst limit change that does not apply until the next tenure, and slot 0 letting a burst run for many beats.

// File: rtl/slv_arb_pkg.sv
package slv_arb_pkg;
   typedef enum logic [1:0] {
      PARK_NONE  = 2'd0,
      PARK_LAST  = 2'd1,
      PARK_FIXED = 2'd2,
      PARK_RSVD  = 2'd3
   } park_mode_e;
endpackage

// File: rtl/slv_arb_cfg.sv
module slv_arb_cfg
   import slv_arb_pkg::*;
#(
   parameter int SLOT_W   = 8,
   parameter int IDX_W    = 3,
   parameter int RST_SLOT = 16,
   parameter int RST_FIX  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [1:0]        wr_mode,
   input  logic [IDX_W-1:0]  wr_fix,
   input  logic              load,
   output park_mode_e        sh_mode,
   output logic [IDX_W-1:0]  sh_fix,
   output logic [SLOT_W-1:0] act_slot
);
   logic [SLOT_W-1:0] sh_slot;

   if (RST_SLOT >= (1 << SLOT_W)) begin : g_bad_rst_slot
      $error("RST_SLOT does not fit in SLOT_W bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_slot <= SLOT_W'(RST_SLOT);
         sh_mode <= PARK_LAST;
         sh_fix  <= IDX_W'(RST_FIX);
      end else if (wr_en) begin
         sh_slot <= wr_slot;
         sh_mode <= park_mode_e'(wr_mode);
         sh_fix  <= wr_fix;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    act_slot <= SLOT_W'(RST_SLOT);
      else if (load) act_slot <= sh_slot;
   end

   // R9
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(act_slot));
endmodule

// File: rtl/slv_arb_rr.sv
module slv_arb_rr #(
   parameter int N_MST = 5,
   parameter int IDX_W = 3
) (
   input  logic [N_MST-1:0] cand,
   input  logic [IDX_W-1:0] start,
   output logic             found,
   output logic [IDX_W-1:0] win
);
   always_comb begin
      found = 1'b0;
      win   = '0;
      for (int k = 1; k <= N_MST; k++) begin
         int j;
         j = (int'(start) + k) % N_MST;
         if (!found && cand[j]) begin
            found = 1'b1;
            win   = IDX_W'(j);
         end
      end
   end
endmodule

// File: rtl/slv_arb_slot.sv
module slv_arb_slot #(
   parameter int SLOT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat,
   input  logic              arb_pt,
   input  logic [SLOT_W-1:0] limit,
   output logic              expire
);
   logic [SLOT_W-1:0] cnt;
   logic [SLOT_W:0]   nxt;

   assign nxt    = {1'b0, cnt} + 1'b1;
   assign expire = beat && (limit != '0) && (nxt >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (arb_pt) cnt <= '0;
      else             cnt <= nxt[SLOT_W-1:0];
   end

   // R4
   slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (limit != '0) |-> (cnt < limit));
endmodule

// File: rtl/slave_arb_park.sv
module slave_arb_park
   import slv_arb_pkg::*;
#(
   parameter int N_MST    = 5,
   parameter int SLOT_W   = 8,
   parameter int IDX_W    = 3,
   parameter int RST_SLOT = 16,
   parameter int RST_PARK = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_MST-1:0]  req,
   input  logic              last_beat,
   input  logic              cfg_we,
   input  logic [SLOT_W-1:0] cfg_slot,
   input  logic [1:0]        cfg_mode,
   input  logic [IDX_W-1:0]  cfg_fix,
   output logic [N_MST-1:0]  gnt,
   output logic              connected,
   output logic [IDX_W-1:0]  conn_idx
);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N_MST - 1);

   if (N_MST < 2 || N_MST > (1 << IDX_W)) begin : g_bad_n
      $error("N_MST must be 2..2**IDX_W");
   end
   if (RST_PARK >= N_MST) begin : g_bad_park
      $error("RST_PARK out of range");
   end

   logic              conn_q;
   logic [IDX_W-1:0]  own_q;
   logic [N_MST-1:0]  own_oh;
   logic              beat, expire, tenure_end, arb_pt, found;
   logic [N_MST-1:0]  cand;
   logic [IDX_W-1:0]  win, sh_fix;
   logic [SLOT_W-1:0] act_slot;
   park_mode_e        sh_mode;

   for (genvar i = 0; i < N_MST; i++) begin : g_oh
      assign own_oh[i] = (own_q == IDX_W'(i));
   end

   assign beat       = conn_q && |(req & own_oh);
   assign tenure_end = beat && (last_beat || expire);
   assign arb_pt     = !beat || tenure_end;
   assign cand       = (beat && last_beat) ? (req & ~own_oh) : req;

   slv_arb_cfg #(.SLOT_W(SLOT_W), .IDX_W(IDX_W), .RST_SLOT(RST_SLOT),
                 .RST_FIX(RST_PARK)) i_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_slot(cfg_slot),
      .wr_mode(cfg_mode), .wr_fix(cfg_fix), .load(arb_pt),
      .sh_mode(sh_mode), .sh_fix(sh_fix), .act_slot(act_slot));

   slv_arb_rr #(.N_MST(N_MST), .IDX_W(IDX_W)) i_rr (
      .cand(cand), .start(own_q), .found(found), .win(win));

   slv_arb_slot #(.SLOT_W(SLOT_W)) i_slot (
      .clk(clk), .rst_n(rst_n), .beat(beat), .arb_pt(arb_pt),
      .limit(act_slot), .expire(expire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conn_q <= 1'b1;
         own_q  <= IDX_W'(RST_PARK);
      end else if (arb_pt) begin
         if (found) begin
            conn_q <= 1'b1;
            own_q  <= win;
         end else begin
            case (sh_mode)
               PARK_LAST:  conn_q <= 1'b1;
               PARK_FIXED: begin
                  conn_q <= 1'b1;
                  own_q  <= (sh_fix > TOP_IDX) ? '0 : sh_fix;
               end
               default:    conn_q <= 1'b0;
            endcase
         end
      end
   end

   assign gnt       = conn_q ? own_oh : '0;
   assign connected = conn_q;
   assign conn_idx  = own_q;

   // R1
   gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt) && (connected == (gnt != '0)));
   // R3
   tenure_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arb_pt |=> $stable(gnt));
   // R3
   last_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && last_beat && found) |=> (conn_idx != $past(conn_idx)));
   // R2
   rr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_pt && found) |=> (connected && conn_idx == $past(win)));
   // R5
   park_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_pt && !found && (sh_mode == PARK_NONE || sh_mode == PARK_RSVD))
      |=> !connected);
   // R6
   park_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_pt && !found && sh_mode == PARK_LAST)
      |=> (connected && $stable(conn_idx)));
   // R7
   park_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_pt && !found && sh_mode == PARK_FIXED && sh_fix > TOP_IDX)
      |=> (connected && conn_idx == '0));
endmodule

// File: tb/test_slave_arb_park.sv
module test_slave_arb_park;
   localparam int N = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] req = '0;
   logic       last_beat = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_slot = '0;
   logic [1:0] cfg_mode = '0;
   logic [2:0] cfg_fix = '0;
   logic [4:0] gnt;
   logic       connected;
   logic [2:0] conn_idx;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // model state
   bit m_conn;
   int m_own, m_cnt, m_act, sh_slot, sh_mode, sh_fix;

   always #4 clk = ~clk;

   slave_arb_park i_slave_arb_park (
      .clk(clk), .rst_n(rst_n), .req(req), .last_beat(last_beat),
      .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_mode(cfg_mode),
      .cfg_fix(cfg_fix), .gnt(gnt), .connected(connected),
      .conn_idx(conn_idx));

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int exp_gnt();
      return m_conn ? (1 << m_own) : 0;
   endfunction

   task automatic cyc(logic [4:0] r, bit l, bit we, int s, int md, int fx);
      bit beat, tend, arb, fnd;
      int win, nconn, nown, ncnt, nact;
      logic [4:0] cand;
      @(negedge clk);
      req = r; last_beat = l; cfg_we = we;
      cfg_slot = 8'(s); cfg_mode = 2'(md); cfg_fix = 3'(fx);
      beat = m_conn && r[m_own];
      tend = beat && (l || (m_act != 0 && m_cnt + 1 >= m_act));
      arb  = !beat || tend;
      cand = r;
      if (beat && l) cand[m_own] = 1'b0;
      fnd = 0; win = 0;
      for (int k = 1; k <= N; k++) begin
         int j;
         j = (m_own + k) % N;
         if (!fnd && cand[j]) begin fnd = 1; win = j; end
      end
      nconn = m_conn; nown = m_own; nact = m_act;
      ncnt = arb ? 0 : m_cnt + 1;
      if (arb) begin
         nact = sh_slot;
         if (fnd) begin nconn = 1; nown = win; end
         else if (sh_mode == 1) nconn = 1;
         else if (sh_mode == 2) begin nconn = 1; nown = (sh_fix > 4) ? 0 : sh_fix; end
         else nconn = 0;
      end
      @(posedge clk);
      #1;
      m_conn = nconn[0]; m_own = nown; m_cnt = ncnt; m_act = nact;
      if (we) begin sh_slot = s; sh_mode = md; sh_fix = fx; end
      chk(gnt == 5'(exp_gnt()) && connected == m_conn && (!m_conn || conn_idx == 3'(m_own)),
          "R1 grant vs model", int'(gnt), exp_gnt());
   endtask

   task automatic expect_gnt(logic [4:0] e, string tag);
      chk(gnt == e, tag, int'(gnt), int'(e));
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      m_conn = 1; m_own = 0; m_cnt = 0; m_act = 16;
      sh_slot = 16; sh_mode = 1; sh_fix = 0;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      // R10 reset state
      chk(gnt == 5'b00001 && connected && conn_idx == 0, "R10 reset park", int'(gnt), 1);

      // R6 parked master 0 starts at once, ends with last beat
      cyc(5'b00001, 0, 0, 0, 0, 0);
      expect_gnt(5'b00001, "R6 parked hit");
      cyc(5'b00001, 1, 0, 0, 0, 0);
      cyc(5'b00000, 0, 0, 0, 0, 0);
      expect_gnt(5'b00001, "R6 stays on last");

      // R5 no-park mode
      cyc(5'b00000, 0, 1, 16, 0, 0);
      expect_gnt(5'b00001, "R9 write not yet used");
      cyc(5'b00000, 0, 0, 0, 0, 0);
      expect_gnt(5'b00000, "R5 disconnected");
      cyc(5'b00100, 0, 0, 0, 0, 0);
      expect_gnt(5'b00100, "R5 grant after connection cycle");
      cyc(5'b00100, 1, 0, 0, 0, 0);
      expect_gnt(5'b00000, "R3 last beat releases");

      // R6 last mode reconnects to master 2
      cyc(5'b00000, 0, 1, 16, 1, 0);
      cyc(5'b00000, 0, 0, 0, 0, 0);
      expect_gnt(5'b00100, "R6 reconnect to last");

      // R8 parked master beats others
      cyc(5'b01101, 0, 0, 0, 0, 0);
      expect_gnt(5'b00100, "R8 parked keeps slave");
      cyc(5'b01101, 1, 0, 0, 0, 0);
      expect_gnt(5'b01000, "R2 next after 2 is 3");
      cyc(5'b01001, 1, 0, 0, 0, 0);
      expect_gnt(5'b00001, "R2 wrap to 0");

      // R4 slot limit 3
      cyc(5'b00000, 0, 1, 3, 1, 0);
      cyc(5'b00000, 0, 0, 0, 0, 0);
      cyc(5'b00011, 0, 0, 0, 0, 0);
      cyc(5'b00011, 0, 0, 0, 0, 0);
      expect_gnt(5'b00001, "R4 within limit");
      cyc(5'b00011, 0, 0, 0, 0, 0);
      expect_gnt(5'b00010, "R4 expiry hands over");
      for (int i = 0; i < 7; i++) begin
         cyc(5'b00010, 0, 0, 0, 0, 0);
         expect_gnt(5'b00010, "R4 no gap when alone");
      end
      // now master 1 is on beat 1 of a fresh tenure (7 = 3+3+1)
      cyc(5'b00110, 0, 1, 6, 1, 0);
      expect_gnt(5'b00010, "R9 mid-burst write");
      cyc(5'b00110, 0, 0, 0, 0, 0);
      expect_gnt(5'b00100, "R9 old limit kept");
      for (int i = 0; i < 5; i++) cyc(5'b00110, 0, 0, 0, 0, 0);
      expect_gnt(5'b00100, "R9 new limit active");
      cyc(5'b00110, 0, 0, 0, 0, 0);
      expect_gnt(5'b00010, "R9 new limit expiry");

      // R4 slot 0 no limit
      cyc(5'b00010, 1, 1, 0, 1, 0);
      cyc(5'b00000, 0, 0, 0, 0, 0);
      for (int i = 0; i < 300; i++) cyc(5'b00011, 0, 0, 0, 0, 0);
      expect_gnt(5'b00010, "R4 unlimited");
      cyc(5'b00011, 1, 0, 0, 0, 0);
      expect_gnt(5'b00001, "R3 last beat ends unlimited");

      // R7 fixed mode
      cyc(5'b00001, 1, 1, 16, 2, 3);
      cyc(5'b00000, 0, 0, 0, 0, 0);
      expect_gnt(5'b01000, "R7 fixed index 3");
      cyc(5'b00000, 0, 1, 16, 2, 7);
      cyc(5'b00000, 0, 0, 0, 0, 0);
      expect_gnt(5'b00001, "R7 index 7 parks on 0");
      cyc(5'b00000, 0, 1, 16, 3, 0);
      cyc(5'b00000, 0, 0, 0, 0, 0);
      expect_gnt(5'b00000, "R5 reserved mode disconnects");

      // random traffic against the model
      for (int i = 0; i < 6000; i++) begin
         logic [4:0] r;
         bit we;
         int s;
         r  = 5'($urandom) & 5'($urandom);
         we = ($urandom % 40) == 0;
         case ($urandom % 5)
            0: s = 0;
            1: s = 1;
            2: s = 2;
            3: s = 5;
            default: s = $urandom % 256;
         endcase
         cyc(r, ($urandom % 4) == 0, we, s, $urandom % 4, $urandom % 8);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule